// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a small distributed shared-memory machine. It owns a range of memory blocks and, for each one, keeps a coherence state and a bit vector naming the processors that hold a copy. Caches send it read misses, write misses and write-backs, each tagged with the requesting processor and the block address. The controller updates its table, stores write-back data into its local memory, and emits outgoing messages: invalidations to sharers, fetch or fetch-and-invalidate to an owner, and a data reply to the requester.

One request is handled at a time. `req_ready` is high only while the controller is idle. A request that needs the owner's copy parks the controller until the owner's data arrives on the fetch-response input. That data is written to memory and forwarded in the reply. Invalidations go out one per cycle, lowest processor number first, before the reply.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid` is 0, and every block is uncached. A first miss to any block is answered by a data reply alone.
- R2: A read miss (`req_op`=0) to an uncached block yields one data reply (`msg_op`=3) to the requester carrying memory contents. The block becomes shared with the requester as its only sharer.
- R3: A write miss (`req_op`=1) to an uncached block yields one data reply to the requester carrying memory contents. The block becomes exclusive with the requester as owner.
- R4: A read miss to a shared block adds the requester to the sharers and yields one data reply with memory contents. The block stays shared.
- R5: A write miss to a shared block first sends an invalidate (`msg_op`=0) to each sharer other than the requester, one per consecutive cycle, in ascending processor order. It then sends the data reply, and the requester becomes sole owner of an exclusive block.
- R6: A read miss to an exclusive block sends a fetch (`msg_op`=1) to the owner and waits for `fwb_valid`. That data is written to memory and returned in the reply. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_op`=2) to the owner and waits for `fwb_valid`. It replies with that data, and the block stays exclusive with the requester as the new owner.
- R8: A write-back (`req_op`=2) from the owner of an exclusive block writes `req_data` to memory, emits no message, and leaves the block uncached.
- R9: A write-back from a processor that is not the owner of an exclusive block emits no message and changes neither memory nor the directory state.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the last outgoing message of that request is presented. Every miss receives exactly one data reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_proc | input | PW | Requesting processor number |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| fwb_valid | input | 1 | Owner's data in response to a fetch |
| fwb_data | input | DW | Owner's block data |
| msg_valid | output | 1 | Outgoing message present (one cycle) |
| msg_op | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dest | output | PW | Destination processor |
| msg_addr | output | AW | Block address of the message |
| msg_data | output | DW | Reply data (zero for other messages) |

## Verification
The hardest cases to reach from the ports are a write miss that meets many sharers, and any miss that meets an exclusive owner. The first needs several earlier read misses to build up the sharer set. The second needs a prior write miss and a bench that answers the fetch. The bench keeps its own directory and owner-data model and issues a long pseudo-random mix of misses and write-backs from owners and non-owners over eight blocks and four processors. It answers every fetch with the owner's current value, so every state and transition recurs many times. Directed sequences add a full-sharer upgrade and a sole-sharer upgrade that must produce no invalidates.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [1:0] {D_UNC = 2'd0, D_SHD = 2'd1, D_EXC = 2'd2} dstate_t;
  typedef enum logic [2:0] {C_IDLE, C_DECIDE, C_INV, C_WAIT, C_REPLY} cstate_t;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_WBACK = 2'd2;

  localparam logic [1:0] MS_INV   = 2'd0;
  localparam logic [1:0] MS_FETCH = 2'd1;
  localparam logic [1:0] MS_FINV  = 2'd2;
  localparam logic [1:0] MS_REPLY = 2'd3;
endpackage

// File: rtl/hdir_lowbit.sv
module hdir_lowbit #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hdir_mem.sv
module hdir_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          fwb_valid,
  input  logic [DW-1:0] fwb_data,
  output logic          msg_valid,
  output logic [1:0]    msg_op,
  output logic [PW-1:0] msg_dest,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  localparam logic [NPROC-1:0] ONE_P = NPROC'(1);

  cstate_t           state;
  dstate_t           dir_st [NBLK];
  logic [NPROC-1:0]  dir_sh [NBLK];

  logic [1:0]        cur_op;
  logic [PW-1:0]     cur_proc;
  logic [AW-1:0]     cur_addr;
  logic [DW-1:0]     cur_data;
  logic [NPROC-1:0]  pend;
  logic [DW-1:0]     hold_data;
  logic              hold_use;

  dstate_t           ent_st;
  logic [NPROC-1:0]  ent_sh;
  logic [NPROC-1:0]  req_bit;
  logic [PW-1:0]     owner_idx;
  logic [PW-1:0]     inv_idx;
  logic [NPROC-1:0]  pend_next;
  logic              mem_we;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata;
  logic              wb_accept;

  assign req_ready = (state == C_IDLE);
  assign ent_st    = dir_st[cur_addr];
  assign ent_sh    = dir_sh[cur_addr];
  assign req_bit   = ONE_P << cur_proc;
  assign pend_next = pend & ~(ONE_P << inv_idx);
  assign wb_accept = (state == C_DECIDE) && (cur_op == RQ_WBACK) &&
                     (ent_st == D_EXC) && ent_sh[cur_proc];
  assign mem_we    = wb_accept || ((state == C_WAIT) && fwb_valid);
  assign mem_wdata = (state == C_WAIT) ? fwb_data : cur_data;

  hdir_lowbit #(.W(NPROC), .IW(PW)) u_owner (.vec(ent_sh), .idx(owner_idx));
  hdir_lowbit #(.W(NPROC), .IW(PW)) u_inv   (.vec(pend),   .idx(inv_idx));

  hdir_mem #(.DW(DW), .DEPTH(NBLK), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cur_addr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= C_IDLE;
      msg_valid <= 1'b0;
      msg_op    <= MS_INV;
      msg_dest  <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
      cur_op    <= RQ_READ;
      cur_proc  <= '0;
      cur_addr  <= '0;
      cur_data  <= '0;
      pend      <= '0;
      hold_data <= '0;
      hold_use  <= 1'b0;
      for (int b = 0; b < NBLK; b++) begin
        dir_st[b] <= D_UNC;
        dir_sh[b] <= '0;
      end
    end else begin
      msg_valid <= 1'b0;
      case (state)
        C_IDLE: begin
          if (req_valid) begin
            cur_op   <= req_op;
            cur_proc <= req_proc;
            cur_addr <= req_addr;
            cur_data <= req_data;
            hold_use <= 1'b0;
            state    <= C_DECIDE;
          end
        end
        C_DECIDE: begin
          case (cur_op)
            RQ_READ: begin
              if (ent_st == D_EXC) begin
                msg_valid <= 1'b1;
                msg_op    <= MS_FETCH;
                msg_dest  <= owner_idx;
                msg_addr  <= cur_addr;
                msg_data  <= '0;
                state     <= C_WAIT;
              end else begin
                dir_sh[cur_addr] <= (ent_st == D_SHD) ? (ent_sh | req_bit) : req_bit;
                dir_st[cur_addr] <= D_SHD;
                state            <= C_REPLY;
              end
            end
            RQ_WRITE: begin
              if (ent_st == D_EXC) begin
                msg_valid <= 1'b1;
                msg_op    <= MS_FINV;
                msg_dest  <= owner_idx;
                msg_addr  <= cur_addr;
                msg_data  <= '0;
                state     <= C_WAIT;
              end else if ((ent_st == D_SHD) && ((ent_sh & ~req_bit) != '0)) begin
                pend  <= ent_sh & ~req_bit;
                state <= C_INV;
              end else begin
                dir_sh[cur_addr] <= req_bit;
                dir_st[cur_addr] <= D_EXC;
                state            <= C_REPLY;
              end
            end
            default: begin
              if (wb_accept) begin
                dir_sh[cur_addr] <= '0;
                dir_st[cur_addr] <= D_UNC;
              end
              state <= C_IDLE;
            end
          endcase
        end
        C_INV: begin
          msg_valid <= 1'b1;
          msg_op    <= MS_INV;
          msg_dest  <= inv_idx;
          msg_addr  <= cur_addr;
          msg_data  <= '0;
          pend      <= pend_next;
          if (pend_next == '0) begin
            dir_sh[cur_addr] <= req_bit;
            dir_st[cur_addr] <= D_EXC;
            state            <= C_REPLY;
          end
        end
        C_WAIT: begin
          if (fwb_valid) begin
            hold_data <= fwb_data;
            hold_use  <= 1'b1;
            if (cur_op == RQ_READ) begin
              dir_sh[cur_addr] <= ent_sh | req_bit;
              dir_st[cur_addr] <= D_SHD;
            end else begin
              dir_sh[cur_addr] <= req_bit;
              dir_st[cur_addr] <= D_EXC;
            end
            state <= C_REPLY;
          end
        end
        C_REPLY: begin
          msg_valid <= 1'b1;
          msg_op    <= MS_REPLY;
          msg_dest  <= cur_proc;
          msg_addr  <= cur_addr;
          msg_data  <= hold_use ? hold_data : mem_rdata;
          state     <= C_IDLE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  // R10: invalidates and fetches only appear while a request is in flight
  a_r10_ctl_busy: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_op != MS_REPLY) |-> (state != C_IDLE));

  // R10: the reply is the last message, the controller is idle when it shows
  a_r10_reply_last: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_op == MS_REPLY) |-> (state == C_IDLE));

  // R5: each cycle in the invalidate phase retires exactly one sharer
  a_r5_one_inv: assert property (@(posedge clk) disable iff (rst)
    (state == C_INV) |=> ($countones(pend) == $countones($past(pend)) - 1));

  // R6/R7: waiting for owner data only after a fetch went out
  a_r6_wait_after_fetch: assert property (@(posedge clk) disable iff (rst)
    (state == C_DECIDE) ##1 (state == C_WAIT) |->
      (msg_valid && (msg_op == MS_FETCH || msg_op == MS_FINV)));

  // R3: an exclusive block always has exactly one owner
  a_r3_one_owner: assert property (@(posedge clk) disable iff (rst)
    (ent_st == D_EXC) |-> ($countones(ent_sh) == 1));

  // R2: a replied block is held by someone afterwards
  a_r2_reply_cached: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_op == MS_REPLY) |-> (ent_st != D_UNC && ent_sh[msg_dest]));
endmodule

// File: tb/home_dir_ctrl_tb.sv
module home_dir_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [PW-1:0] req_proc;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          fwb_valid;
  logic [DW-1:0] fwb_data;
  logic          msg_valid;
  logic [1:0]    msg_op;
  logic [PW-1:0] msg_dest;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  home_dir_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
    .fwb_valid(fwb_valid), .fwb_data(fwb_data),
    .msg_valid(msg_valid), .msg_op(msg_op), .msg_dest(msg_dest),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model: 0 uncached, 1 shared, 2 exclusive
  int          m_st  [NB];
  logic [NP-1:0] m_sh [NB];
  logic [DW-1:0] m_mem [NB];
  logic [DW-1:0] own_val [NB];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int owner_of(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [DW-1:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  task automatic do_req(input logic [1:0] op, input int p, input int a,
                        input logic [DW-1:0] d, input bit chk_data);
    int e_op [8]; int e_dst [8]; logic [DW-1:0] e_dat [8]; int n_e = 0;
    int g_op [16]; int g_dst [16]; int g_adr [16]; logic [DW-1:0] g_dat [16]; int g_cyc [16];
    int n_g = 0;
    bit done = 0;
    string rq;
    int own = owner_of(m_sh[a]);
    logic [DW-1:0] rdat;
    // expected messages from the model
    if (op == 2'd0) begin
      if (m_st[a] == 2) begin
        rq = "R6"; e_op[0] = 1; e_dst[0] = own; n_e = 1; rdat = own_val[a];
      end else begin
        rq = (m_st[a] == 0) ? "R2" : "R4"; rdat = m_mem[a];
      end
      e_op[n_e] = 3; e_dst[n_e] = p; e_dat[n_e] = rdat; n_e++;
    end else if (op == 2'd1) begin
      if (m_st[a] == 2) begin
        rq = "R7"; e_op[0] = 2; e_dst[0] = own; n_e = 1; rdat = own_val[a];
      end else begin
        rq = (m_st[a] == 0) ? "R3" : "R5"; rdat = m_mem[a];
        if (m_st[a] == 1)
          for (int i = 0; i < NP; i++)
            if (m_sh[a][i] && i != p) begin e_op[n_e] = 0; e_dst[n_e] = i; n_e++; end
      end
      e_op[n_e] = 3; e_dst[n_e] = p; e_dat[n_e] = rdat; n_e++;
    end else begin
      rq = (m_st[a] == 2 && m_sh[a][p]) ? "R8" : "R9";
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_proc = PW'(p); req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", 32'(req_ready), 0);
    for (int t = 0; t < 40 && !done; t++) begin
      @(negedge clk);
      fwb_valid = 1'b0;
      if (msg_valid && n_g < 16) begin
        g_op[n_g] = int'(msg_op); g_dst[n_g] = int'(msg_dest); g_adr[n_g] = int'(msg_addr);
        g_dat[n_g] = msg_data; g_cyc[n_g] = cyc; n_g++;
        if (msg_op == 2'd1 || msg_op == 2'd2) begin
          fwb_valid = 1'b1; fwb_data = own_val[a];
        end
        if (msg_op == 2'd3) begin
          done = 1;
          chk(req_ready, "R10", 32'(req_ready), 1);
        end else begin
          chk(!req_ready, "R10", 32'(req_ready), 0);
        end
      end
      if (op == 2'd2 && req_ready) done = 1;
    end
    fwb_valid = 1'b0;
    chk(done, "R10", 32'(done), 1);
    chk(n_g == n_e, rq, 32'(n_g), 32'(n_e));
    for (int k = 0; k < n_e && k < n_g; k++) begin
      chk(g_op[k] == e_op[k], rq, 32'(g_op[k]), 32'(e_op[k]));
      chk(g_dst[k] == e_dst[k], rq, 32'(g_dst[k]), 32'(e_dst[k]));
      chk(g_adr[k] == a, rq, 32'(g_adr[k]), 32'(a));
      if (e_op[k] == 3 && chk_data) chk(g_dat[k] === e_dat[k], rq, 32'(g_dat[k]), 32'(e_dat[k]));
      if (e_op[k] == 0 && k > 0 && e_op[k-1] == 0)
        chk(g_cyc[k] == g_cyc[k-1] + 1, "R5", 32'(g_cyc[k]), 32'(g_cyc[k-1] + 1));
    end

    // model update
    if (op == 2'd0) begin
      if (m_st[a] == 2) m_mem[a] = own_val[a];
      m_sh[a] = (m_st[a] == 0) ? (NP'(1) << p) : (m_sh[a] | (NP'(1) << p));
      m_st[a] = 1;
    end else if (op == 2'd1) begin
      if (m_st[a] == 2) m_mem[a] = own_val[a];
      m_sh[a] = NP'(1) << p; m_st[a] = 2;
      own_val[a] = next_rand();
    end else if (m_st[a] == 2 && m_sh[a][p]) begin
      m_mem[a] = d; m_sh[a] = '0; m_st[a] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_proc = '0; req_addr = '0;
    req_data = '0; fwb_valid = 1'b0; fwb_data = '0;
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; own_val[b] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: idle after reset
    chk(req_ready, "R1", 32'(req_ready), 1);
    chk(!msg_valid, "R1", 32'(msg_valid), 0);

    // R1: every block starts uncached; fill memory through write-backs (R8)
    for (int b = 0; b < NB; b++) begin
      do_req(2'd1, b % NP, b, '0, 1'b0);
      do_req(2'd2, b % NP, b, own_val[b], 1'b1);
    end

    // R5: all four share block 0, then processor 2 upgrades
    for (int p = 0; p < NP; p++) do_req(2'd0, p, 0, '0, 1'b1);
    do_req(2'd1, 2, 0, '0, 1'b1);
    // R9: non-owner write-back ignored, then R6 fetch from owner
    do_req(2'd2, 1, 0, 16'hBEEF, 1'b1);
    do_req(2'd0, 3, 0, '0, 1'b1);
    // R5: sole sharer upgrade, no invalidates
    do_req(2'd0, 1, 1, '0, 1'b1);
    do_req(2'd1, 1, 1, '0, 1'b1);
    // R7: ownership moves, R9 on uncached block
    do_req(2'd1, 0, 1, '0, 1'b1);
    do_req(2'd2, 2, 2, 16'h1111, 1'b1);
    do_req(2'd0, 0, 2, '0, 1'b1);

    // pseudo-random sweep over all blocks, processors and operations
    for (int n = 0; n < 2000; n++) begin
      logic [DW-1:0] r = next_rand();
      int a = int'(r[2:0]);
      int p = int'(r[4:3]);
      int k = int'(r[6:5]);
      logic [1:0] op = (k == 3) ? 2'd2 : 2'(k);
      if (m_st[a] == 2 && m_sh[a][p] && op != 2'd2) op = 2'd2;
      if (k == 2 && m_st[a] == 2) p = owner_of(m_sh[a]);
      do_req(op, p, a, (op == 2'd2 && m_st[a] == 2 && m_sh[a][p]) ? own_val[a] : next_rand(), 1'b1);
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule